// File: doc/BRIEF.md
# Dual I/O Window Base Decoder

This block holds the configuration state that places two I/O-space windows for a power-management function. One window is 128 bytes and carries event and control registers. The other is 16 bytes and carries a two-wire management bus controller. The contents of the windows are outside this block. It only decides whether an incoming I/O address lands in either window, and at which offset.

Software sets up the windows with byte-enabled 32-bit configuration writes. Each window has a base register. The base register corrects itself on every write that touches it: address bits below the window size are dropped, the bits above bit 15 are dropped, and bit 0 always reads as 1. Each window also has its own enable bit, which sits in a separate configuration byte. The decoders compare an I/O address with each enabled base and report a hit together with the low address bits. If both windows would claim the same address, the event window wins.

Configuration reads are combinational from the registered state. A write takes effect at the clock edge that samples it, and the hit outputs follow the new state straight after that edge.

Top module: `pmw_window_decoder`

## Requirements
- R1: After reset, the dword at config byte address 0x48 and the dword at 0x90 both read 0x00000001. The dwords at 0x40 and 0xD0 read 0x00000000. Neither hit output is asserted for any I/O address.
- R2: A write with at least one byte enable set to the dword at 0x48 first merges the enabled byte lanes into its current read value. The result is then masked with 0x0000FF80 and bit 0 is set to 1. The event base is read bits 15:7.
- R3: A write with at least one byte enable set to the dword at 0x90 first merges the enabled lanes into its current read value. The result is then masked with 0x0000FFF0 and bit 0 is set to 1. The management-bus base is read bits 15:4.
- R4: The event enable byte sits at config byte 0x41, which is byte lane 1 (bits 15:8) of dword 0x40. All 8 bits are writable, and bit 7 of this byte enables the event window.
- R5: The management-bus enable byte sits at config byte 0xD2, which is byte lane 2 (bits 23:16) of dword 0xD0. A write keeps only bits 3:0 of the byte, and bit 0 of this byte enables the management-bus window.
- R6: `evt_hit` is 1 exactly when the event window is enabled and io_addr[15:7] equals the event base. `evt_off` is io_addr[6:0] while hit and 0 otherwise.
- R7: `smb_hit` is 1 exactly when the management-bus window is enabled, io_addr[15:4] equals its base, and `evt_hit` is 0. `smb_off` is io_addr[3:0] while hit and 0 otherwise.
- R8: When both windows match the same address, only `evt_hit` is asserted.
- R9: Every other config dword, and every other byte lane inside dwords 0x40 and 0xD0, reads 0. Writes there change no readable register and no hit output.
- R10: A write with all byte enables clear changes no register.
- R11: Reads and hit outputs show a write's effect in the cycle straight after the clock edge that sampled it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address; bits 1:0 are ignored |
| cfg_be | input | 4 | Byte enables for the write, one per lane |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the dword at cfg_addr |
| io_addr | input | 16 | I/O address to decode |
| evt_hit | output | 1 | Address falls in the enabled event window |
| evt_off | output | 7 | Offset inside the event window |
| smb_hit | output | 1 | Address falls in the enabled management-bus window, with no event hit |
| smb_off | output | 4 | Offset inside the management-bus window |

## Verification
The bench builds the block with its default parameters. These give a 128-byte event window, a 16-byte management-bus window, and the register offsets 0x41, 0x48, 0x90 and 0xD2. Because the management-bus base has finer granularity, the bench can place it inside the event window. That lets both directed and random cases reach the priority rule. Random I/O addresses are drawn close to the current bases, so hits, edge offsets and near misses come up often, and are not left to 16-bit chance.

// File: rtl/pmw_pkg.sv
package pmw_pkg;
    localparam int unsigned CFG_DW    = 32;
    localparam int unsigned CFG_LANES = CFG_DW / 8;

    typedef logic [CFG_DW-1:0]    cfg_word_t;
    typedef logic [CFG_LANES-1:0] cfg_be_t;

    // Replace each byte lane of old_w whose enable is set with new_w's lane
    function automatic cfg_word_t lane_merge(cfg_word_t old_w, cfg_word_t new_w, cfg_be_t be);
        cfg_word_t r;
        for (int i = 0; i < int'(CFG_LANES); i++) begin
            r[i*8 +: 8] = be[i] ? new_w[i*8 +: 8] : old_w[i*8 +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/pmw_base_reg.sv
module pmw_base_reg
    import pmw_pkg::*;
#(
    parameter int unsigned CFG_AW   = 8,
    parameter int unsigned OFS      = 8'h48,
    parameter int unsigned IO_AW    = 16,
    parameter int unsigned WIN_LOG2 = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [CFG_AW-3:0]       wr_dw,
    input  cfg_be_t                 wr_be,
    input  cfg_word_t               wr_data,
    input  logic [CFG_AW-3:0]       rd_dw,
    output logic [IO_AW-1:WIN_LOG2] base_q,
    output cfg_word_t               rd_word
);
    localparam logic [CFG_AW-3:0] MY_DW = (CFG_AW-2)'(OFS >> 2);

    cfg_word_t cur_w;
    cfg_word_t merged_w;
    logic      wr_hit;
    logic      unused_bits;

    // Corrected form as seen by software: base bits, zero elsewhere, bit 0 set
    always_comb begin
        cur_w                     = '0;
        cur_w[IO_AW-1:WIN_LOG2]   = base_q;
        cur_w[0]                  = 1'b1;
    end

    for (genvar g = 0; g < int'(CFG_LANES); g++) begin : g_lane
        assign merged_w[g*8 +: 8] = wr_be[g] ? wr_data[g*8 +: 8] : cur_w[g*8 +: 8];
    end

    assign unused_bits = ^{merged_w[CFG_DW-1:IO_AW], merged_w[WIN_LOG2-1:0]};
    assign wr_hit      = wr_en && (wr_dw == MY_DW) && (|wr_be);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (wr_hit) begin
            base_q <= merged_w[IO_AW-1:WIN_LOG2];
        end
    end

    assign rd_word = (rd_dw == MY_DW) ? cur_w : '0;

    // R10/R9: base only moves on a touching write with some lane enabled
    a_r10_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(base_q));
endmodule

// File: rtl/pmw_en_byte.sv
module pmw_en_byte
    import pmw_pkg::*;
#(
    parameter int unsigned CFG_AW = 8,
    parameter int unsigned OFS    = 8'h41,
    parameter logic [7:0]  KEEP   = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_AW-3:0] wr_dw,
    input  cfg_be_t           wr_be,
    input  cfg_word_t         wr_data,
    input  logic [CFG_AW-3:0] rd_dw,
    output logic [7:0]        byte_q,
    output cfg_word_t         rd_word
);
    localparam logic [CFG_AW-3:0] MY_DW = (CFG_AW-2)'(OFS >> 2);
    localparam int unsigned       LANE  = OFS % 4;

    logic wr_hit;
    logic unused_lanes;

    assign unused_lanes = ^{wr_data, wr_be};
    assign wr_hit       = wr_en && (wr_dw == MY_DW) && wr_be[LANE];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
        end else if (wr_hit) begin
            byte_q <= wr_data[LANE*8 +: 8] & KEEP;
        end
    end

    always_comb begin
        rd_word = '0;
        if (rd_dw == MY_DW) begin
            rd_word[LANE*8 +: 8] = byte_q;
        end
    end

    // R9/R10: the byte moves only when its own lane is written
    a_r9_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(byte_q));
endmodule

// File: rtl/pmw_win_match.sv
module pmw_win_match #(
    parameter int unsigned IO_AW    = 16,
    parameter int unsigned WIN_LOG2 = 7
) (
    input  logic [IO_AW-1:0]        io_addr,
    input  logic [IO_AW-1:WIN_LOG2] base,
    input  logic                    en,
    output logic                    match,
    output logic [WIN_LOG2-1:0]     off
);
    assign match = en && (io_addr[IO_AW-1:WIN_LOG2] == base);
    assign off   = io_addr[WIN_LOG2-1:0];
endmodule

// File: rtl/pmw_window_decoder.sv
module pmw_window_decoder
    import pmw_pkg::*;
#(
    parameter int unsigned CFG_AW       = 8,
    parameter int unsigned IO_AW        = 16,
    parameter int unsigned EVT_LOG2     = 7,
    parameter int unsigned SMB_LOG2     = 4,
    parameter int unsigned EVT_BASE_OFS = 8'h48,
    parameter int unsigned SMB_BASE_OFS = 8'h90,
    parameter int unsigned EVT_EN_OFS   = 8'h41,
    parameter int unsigned SMB_EN_OFS   = 8'hD2,
    parameter int unsigned EVT_EN_BIT   = 7,
    parameter int unsigned SMB_EN_BIT   = 0,
    parameter logic [7:0]  SMB_EN_KEEP  = 8'h0F
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [3:0]          cfg_be,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata,
    input  logic [IO_AW-1:0]    io_addr,
    output logic                evt_hit,
    output logic [EVT_LOG2-1:0] evt_off,
    output logic                smb_hit,
    output logic [SMB_LOG2-1:0] smb_off
);
    localparam int unsigned DW_AW = CFG_AW - 2;

    logic [DW_AW-1:0]          cfg_dw;
    logic [IO_AW-1:EVT_LOG2]   evt_base;
    logic [IO_AW-1:SMB_LOG2]   smb_base;
    logic [7:0]                evt_en_byte;
    logic [7:0]                smb_en_byte;
    cfg_word_t                 rd_evt_base, rd_smb_base, rd_evt_en, rd_smb_en;
    logic                      evt_match, smb_match;
    logic [EVT_LOG2-1:0]       evt_raw_off;
    logic [SMB_LOG2-1:0]       smb_raw_off;
    logic                      unused_top;

    assign cfg_dw     = cfg_addr[CFG_AW-1:2];
    assign unused_top = ^{cfg_addr[1:0], evt_en_byte, smb_en_byte};

    pmw_base_reg #(
        .CFG_AW(CFG_AW), .OFS(EVT_BASE_OFS), .IO_AW(IO_AW), .WIN_LOG2(EVT_LOG2)
    ) i_evt_base (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_dw(cfg_dw), .wr_be(cfg_be),
        .wr_data(cfg_wdata), .rd_dw(cfg_dw), .base_q(evt_base), .rd_word(rd_evt_base)
    );

    pmw_base_reg #(
        .CFG_AW(CFG_AW), .OFS(SMB_BASE_OFS), .IO_AW(IO_AW), .WIN_LOG2(SMB_LOG2)
    ) i_smb_base (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_dw(cfg_dw), .wr_be(cfg_be),
        .wr_data(cfg_wdata), .rd_dw(cfg_dw), .base_q(smb_base), .rd_word(rd_smb_base)
    );

    pmw_en_byte #(
        .CFG_AW(CFG_AW), .OFS(EVT_EN_OFS), .KEEP(8'hFF)
    ) i_evt_en (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_dw(cfg_dw), .wr_be(cfg_be),
        .wr_data(cfg_wdata), .rd_dw(cfg_dw), .byte_q(evt_en_byte), .rd_word(rd_evt_en)
    );

    pmw_en_byte #(
        .CFG_AW(CFG_AW), .OFS(SMB_EN_OFS), .KEEP(SMB_EN_KEEP)
    ) i_smb_en (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_dw(cfg_dw), .wr_be(cfg_be),
        .wr_data(cfg_wdata), .rd_dw(cfg_dw), .byte_q(smb_en_byte), .rd_word(rd_smb_en)
    );

    // Each register drives zero unless selected, so an OR forms the read mux
    assign cfg_rdata = rd_evt_base | rd_smb_base | rd_evt_en | rd_smb_en;

    pmw_win_match #(.IO_AW(IO_AW), .WIN_LOG2(EVT_LOG2)) i_evt_match (
        .io_addr(io_addr), .base(evt_base), .en(evt_en_byte[EVT_EN_BIT]),
        .match(evt_match), .off(evt_raw_off)
    );

    pmw_win_match #(.IO_AW(IO_AW), .WIN_LOG2(SMB_LOG2)) i_smb_match (
        .io_addr(io_addr), .base(smb_base), .en(smb_en_byte[SMB_EN_BIT]),
        .match(smb_match), .off(smb_raw_off)
    );

    // Event window has priority on overlap
    always_comb begin
        evt_hit = evt_match;
        smb_hit = smb_match && !evt_match;
        evt_off = evt_hit ? evt_raw_off : '0;
        smb_off = smb_hit ? smb_raw_off : '0;
    end

    a_r8_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_hit && smb_hit));
    a_r6_evt_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        evt_hit |-> evt_en_byte[EVT_EN_BIT]);
    a_r7_smb_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        smb_hit |-> smb_en_byte[SMB_EN_BIT]);
    a_r4_evt_enable_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_en_byte[EVT_EN_BIT] && !(cfg_wr && cfg_be[1])) |=> !evt_hit);
endmodule

// File: tb/test_pmw_window_decoder.sv
module test_pmw_window_decoder;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [7:0]  cfg_addr;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic [15:0] io_addr;
    logic        evt_hit, smb_hit;
    logic [6:0]  evt_off;
    logic [3:0]  smb_off;

    always #10 clk = ~clk;

    pmw_window_decoder i_pmw_window_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_addr(io_addr),
        .evt_hit(evt_hit), .evt_off(evt_off), .smb_hit(smb_hit), .smb_off(smb_off)
    );

    int   n_checks = 0;
    int   n_fail   = 0;
    logic done     = 1'b0;

    logic [8:0]  m_evt;
    logic [11:0] m_smb;
    logic [7:0]  m_en41;
    logic [3:0]  m_end2;

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a[7:2])
            6'h10:   return {16'h0, m_en41, 8'h00};
            6'h12:   return {16'h0, m_evt, 7'h01};
            6'h24:   return {16'h0, m_smb, 4'h1};
            6'h34:   return {12'h0, m_end2, 16'h0};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic exp_evt(input logic [15:0] io);
        return m_en41[7] && (io[15:7] == m_evt);
    endfunction

    function automatic logic exp_smb(input logic [15:0] io);
        return m_end2[0] && (io[15:4] == m_smb) && !exp_evt(io);
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        logic [31:0] mrg;
        @(negedge clk);
        cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        mrg = exp_rd(a);
        for (int i = 0; i < 4; i++) if (be[i]) mrg[i*8 +: 8] = d[i*8 +: 8];
        case (a[7:2])
            6'h12: if (|be) m_evt = mrg[15:7];
            6'h24: if (|be) m_smb = mrg[15:4];
            6'h10: if (be[1]) m_en41 = d[15:8];
            6'h34: if (be[2]) m_end2 = d[19:16];
            default: ;
        endcase
    endtask

    task automatic check_rd(input string tag, input logic [7:0] a);
        cfg_addr = a;
        #1;
        check(tag, cfg_rdata, exp_rd(a));
    endtask

    task automatic check_all_rd(input string tag);
        check_rd(tag, 8'h40);
        check_rd(tag, 8'h48);
        check_rd(tag, 8'h90);
        check_rd(tag, 8'hD0);
    endtask

    task automatic check_io(input string tag, input logic [15:0] io);
        logic e, s;
        io_addr = io;
        #1;
        e = exp_evt(io);
        s = exp_smb(io);
        check({tag, " evt_hit"}, {31'h0, evt_hit}, {31'h0, e});
        check({tag, " evt_off"}, {25'h0, evt_off}, e ? {25'h0, io[6:0]} : 32'h0);
        check({tag, " smb_hit"}, {31'h0, smb_hit}, {31'h0, s});
        check({tag, " smb_off"}, {28'h0, smb_off}, s ? {28'h0, io[3:0]} : 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_evt = '0; m_smb = '0; m_en41 = '0; m_end2 = '0;
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_be = '0; cfg_wdata = '0; io_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values, constants written out
        cfg_addr = 8'h48; #1; check("R1 evt base", cfg_rdata, 32'h0000_0001);
        cfg_addr = 8'h90; #1; check("R1 smb base", cfg_rdata, 32'h0000_0001);
        cfg_addr = 8'h40; #1; check("R1 evt en", cfg_rdata, 32'h0);
        cfg_addr = 8'hD0; #1; check("R1 smb en", cfg_rdata, 32'h0);
        check_io("R1 no hit", 16'h0000);

        // R2 / R3: self-correcting bases
        cfg_write(8'h48, 4'hF, 32'hFFFF_FFFF);
        cfg_addr = 8'h48; #1; check("R2 full write", cfg_rdata, 32'h0000_FF81);
        cfg_write(8'h48, 4'h2, 32'h0000_1200);
        cfg_addr = 8'h48; #1; check("R2 lane merge", cfg_rdata, 32'h0000_1281);
        cfg_write(8'h90, 4'hF, 32'hFFFF_FFFF);
        cfg_addr = 8'h90; #1; check("R3 full write", cfg_rdata, 32'h0000_FFF1);

        // R10: no byte enables
        cfg_write(8'h48, 4'h0, 32'h0);
        cfg_addr = 8'h48; #1; check("R10 be zero", cfg_rdata, 32'h0000_1281);

        // R4 / R5: enable bytes
        cfg_write(8'h40, 4'h2, 32'h0000_8000);
        cfg_addr = 8'h40; #1; check("R4 evt enable", cfg_rdata, 32'h0000_8000);
        cfg_write(8'hD0, 4'h4, 32'h00FF_0000);
        cfg_addr = 8'hD0; #1; check("R5 keep low nibble", cfg_rdata, 32'h000F_0000);

        // R8: overlapping windows, R11: effect right after the edge
        cfg_write(8'h48, 4'h3, 32'h0000_1000);
        cfg_write(8'h90, 4'h3, 32'h0000_1010);
        io_addr = 16'h1010; #1;
        check("R8 overlap evt", {31'h0, evt_hit}, 32'h1);
        check("R8 overlap smb", {31'h0, smb_hit}, 32'h0);
        check("R11 evt off", {25'h0, evt_off}, 32'h10);

        // R7: management-bus window edges
        cfg_write(8'h90, 4'h3, 32'h0000_2000);
        io_addr = 16'h200F; #1;
        check("R7 smb hit", {31'h0, smb_hit}, 32'h1);
        check("R7 smb off", {28'h0, smb_off}, 32'hF);
        check_io("R7 past end", 16'h2010);

        // R6: event window edges
        io_addr = 16'h107F; #1;
        check("R6 evt last", {31'h0, evt_hit}, 32'h1);
        check("R6 evt off", {25'h0, evt_off}, 32'h7F);
        check_io("R6 past end", 16'h1080);

        // R9: unrelated dwords and lanes
        cfg_write(8'h44, 4'hF, 32'hFFFF_FFFF);
        check_rd("R9 other dword", 8'h44);
        cfg_write(8'h40, 4'hD, 32'hFFFF_FFFF);
        check_all_rd("R9 other lanes");
        check_io("R9 hits kept", 16'h1005);
        check_io("R9 hits kept", 16'h2005);

        // R5: clearing bit 0 disables the window
        cfg_write(8'hD0, 4'h4, 32'h000E_0000);
        check_io("R5 disabled", 16'h2005);

        // Random mix
        for (int it = 0; it < 400; it++) begin
            logic [7:0]  a;
            logic [15:0] io;
            int          sel;
            sel = $urandom_range(0, 4);
            case (sel)
                0: a = 8'h40;
                1: a = 8'h48;
                2: a = 8'h90;
                3: a = 8'hD0;
                default: begin
                    a = 8'($urandom_range(0, 255));
                    if (a[7:2] == 6'h10 || a[7:2] == 6'h12 || a[7:2] == 6'h24 || a[7:2] == 6'h34)
                        a = 8'h44;
                end
            endcase
            cfg_write(a, 4'($urandom), $urandom);
            check_all_rd("R2 R3 R4 R5 random read");
            check_rd("R9 random read", a);
            for (int k = 0; k < 3; k++) begin
                case ($urandom_range(0, 2))
                    0: io = {m_evt, 7'($urandom)};
                    1: io = {m_smb, 4'($urandom)};
                    default: io = 16'($urandom);
                endcase
                check_io("R6 R7 R8 random io", io);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule